// File: doc/BRIEF.md
# CAN Controller Status and Interrupt Identifier

This block holds the status view of a CAN controller and turns its events into one interrupt line. A protocol engine feeds it single-cycle pulses for a successful transmission, a successful reception and a new last-error code. It also feeds it three bus-condition levels: warning limit reached, error passive and bus-off. The message-object store supplies a vector of pending object interrupts, and the engine's error counter values arrive as plain inputs.

Software reaches the block through a two-bit register port. It has four registers: control, status, error-counter view and interrupt identifier. The identifier tells the handler what to serve first. A pending status event always wins and reads as 0x8000. Otherwise the identifier names the lowest-numbered pending message object. The last-error field can be loaded by software with a "no update" value, so a later bus event can be told apart from stale content.

Top module: `can_status_irq`

## Requirements
- R1: After reset the control and status registers read 0, the identifier reads 0 and `irq` is low.
- R2: Status register address 1, bits: 7 bus-off level, 6 warning level, 5 error-passive level (all live), 4 RX-ok flag, 3 TX-ok flag, 2:0 last-error code.
- R3: A last-error event loads its code (0 none, 1 stuff, 2 form, 3 ack, 4 bit1, 5 bit0, 6 CRC) into bits 2:0. A software write to the status register loads bits 2:0 from the written data. The value 7 then stays until the next event. An event in the same cycle as a write wins.
- R4: A TX-ok or RX-ok pulse sets its flag. Writing 0 to the flag's bit in the status register clears it. Writing 1 leaves it unchanged.
- R5: With control bit 2 (status-change enable) set, a TX-ok, RX-ok or last-error event makes a status interrupt pending. With the bit clear, these events make nothing pending.
- R6: With control bit 3 (error enable) set, any change of the bus-off or warning level, in either direction, makes a status interrupt pending. A change of the error-passive level never does.
- R7: A read strobe on the status register clears the pending status interrupt. A new event in the same cycle keeps it pending.
- R8: The identifier register (address 3) reads 0x8000 while a status interrupt is pending, regardless of object interrupts.
- R9: With no status interrupt pending, the identifier reads n+1 for the lowest set bit n of `obj_pend`, and 0 when no bit is set.
- R10: `irq` is high exactly when control bit 1 (module interrupt enable) is set and the identifier is nonzero.
- R11: The error-counter view (address 2) reads transmit count in bits 7:0, receive count in 14:8 and the receive-passive flag in bit 15.
- R12: The control register (address 0) stores written bits 7:0 and reads 0 in bits 15:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 error counters, 3 identifier |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; only side effect is on status |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data (combinational from reg_addr) |
| pe_lec_vld | input | 1 | Last-error event pulse |
| pe_lec | input | 3 | Last-error code carried with the pulse |
| pe_tx_ok | input | 1 | Transmission-complete pulse |
| pe_rx_ok | input | 1 | Reception-complete pulse |
| pe_warn | input | 1 | Warning-limit level |
| pe_passive | input | 1 | Error-passive level |
| pe_busoff | input | 1 | Bus-off level |
| pe_tec | input | 8 | Transmit error count |
| pe_rec | input | 7 | Receive error count |
| pe_rec_passive | input | 1 | Receive-passive flag |
| obj_pend | input | NOBJ | Object interrupt pending; bit n is object n+1 |
| irq | output | 1 | Interrupt line |

## Verification
The bench builds the block with its defaults: NOBJ of 32 and the one-hot lowest-set encoder. This puts the widest identifier value, 32 for the top bit alone, within reach. So are the encoder cases with several bits set, where a low bit must beat higher ones. The 32-bit vector also lets a single stimulus put a status event and an object interrupt side by side, to show the 0x8000 override. The same-cycle collisions in the status path are driven on purpose: event against software write, and event against read-clear.

// File: rtl/cstat_pkg.sv
package cstat_pkg;

   typedef enum logic [2:0] {
      LEC_NONE  = 3'd0,
      LEC_STUFF = 3'd1,
      LEC_FORM  = 3'd2,
      LEC_ACK   = 3'd3,
      LEC_BIT1  = 3'd4,
      LEC_BIT0  = 3'd5,
      LEC_CRC   = 3'd6,
      LEC_NOUPD = 3'd7
   } lec_e;

   // status view, msb first: bus-off, warning, passive, rx ok, tx ok, code
   typedef struct packed {
      logic boff;
      logic warn;
      logic pass;
      logic rxok;
      logic txok;
      lec_e lec;
   } stat_t;

   localparam logic [1:0] ADR_CTRL = 2'd0;
   localparam logic [1:0] ADR_STAT = 2'd1;
   localparam logic [1:0] ADR_ERRC = 2'd2;
   localparam logic [1:0] ADR_IID  = 2'd3;

   localparam int CB_IE  = 1;
   localparam int CB_SIE = 2;
   localparam int CB_EIE = 3;

   localparam logic [15:0] IID_STATUS = 16'h8000;

endpackage

// File: rtl/cstat_status.sv
module cstat_status
   import cstat_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ev_lec_vld,
   input  lec_e       ev_lec,
   input  logic       ev_tx_ok,
   input  logic       ev_rx_ok,
   input  logic       lv_warn,
   input  logic       lv_pass,
   input  logic       lv_boff,
   input  logic       sie,
   input  logic       eie,
   input  logic       cpu_wr,
   input  logic [4:0] cpu_wdata,
   input  logic       cpu_rd,
   output stat_t      stat,
   output logic       stat_pend
);

   logic txok_q, rxok_q, warn_d, boff_d, pend_q;
   lec_e lec_q;
   logic set_stat;

   assign set_stat = (sie & (ev_tx_ok | ev_rx_ok | ev_lec_vld))
                   | (eie & ((lv_warn ^ warn_d) | (lv_boff ^ boff_d)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txok_q <= 1'b0;
         rxok_q <= 1'b0;
         lec_q  <= LEC_NONE;
         warn_d <= 1'b0;
         boff_d <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         if (cpu_wr) begin
            if (!cpu_wdata[3]) txok_q <= 1'b0;
            if (!cpu_wdata[4]) rxok_q <= 1'b0;
            lec_q <= lec_e'(cpu_wdata[2:0]);
         end
         if (ev_tx_ok)   txok_q <= 1'b1;
         if (ev_rx_ok)   rxok_q <= 1'b1;
         if (ev_lec_vld) lec_q  <= ev_lec;
         warn_d <= lv_warn;
         boff_d <= lv_boff;
         pend_q <= set_stat | (pend_q & ~cpu_rd);
      end
   end

   assign stat = '{boff: lv_boff, warn: lv_warn, pass: lv_pass,
                   rxok: rxok_q, txok: txok_q, lec: lec_q};
   assign stat_pend = pend_q;

   a_r3_sentinel_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (lec_q == LEC_NOUPD && !ev_lec_vld && !cpu_wr) |=> (lec_q == LEC_NOUPD));

   a_r4_txok_from_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(txok_q) |-> $past(ev_tx_ok));

   a_r5_event_pends: assert property (@(posedge clk) disable iff (!rst_n)
      (sie && (ev_tx_ok || ev_rx_ok || ev_lec_vld)) |=> pend_q);

   a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && !sie && !eie) |=> !pend_q);

endmodule

// File: rtl/cstat_lowest.sv
module cstat_lowest #(
   parameter int N          = 32,
   parameter bit USE_ONEHOT = 1'b1,
   localparam int IDX_W     = $clog2(N + 1)
) (
   input  logic [N-1:0]     pend,
   output logic             any,
   output logic [IDX_W-1:0] num
);

   if (N < 1) begin : g_bad_n
      $error("cstat_lowest: N must be at least 1");
   end

   assign any = |pend;

   if (USE_ONEHOT) begin : g_onehot
      logic [N-1:0] lowest;
      assign lowest = pend & (~pend + 1'b1);
      always_comb begin
         num = '0;
         for (int i = 0; i < N; i++)
            if (lowest[i]) num = num | IDX_W'(i + 1);
      end
   end else begin : g_scan
      always_comb begin
         num = '0;
         for (int i = N - 1; i >= 0; i--)
            if (pend[i]) num = IDX_W'(i + 1);
      end
   end

endmodule

// File: rtl/can_status_irq.sv
module can_status_irq
   import cstat_pkg::*;
#(
   parameter int NOBJ       = 32,
   parameter bit USE_ONEHOT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      reg_addr,
   input  logic            reg_wr,
   input  logic            reg_rd,
   input  logic [15:0]     reg_wdata,
   output logic [15:0]     reg_rdata,
   input  logic            pe_lec_vld,
   input  logic [2:0]      pe_lec,
   input  logic            pe_tx_ok,
   input  logic            pe_rx_ok,
   input  logic            pe_warn,
   input  logic            pe_passive,
   input  logic            pe_busoff,
   input  logic [7:0]      pe_tec,
   input  logic [6:0]      pe_rec,
   input  logic            pe_rec_passive,
   input  logic [NOBJ-1:0] obj_pend,
   output logic            irq
);

   localparam int IDX_W = $clog2(NOBJ + 1);

   if (NOBJ < 1 || NOBJ > 32767) begin : g_bad_nobj
      $error("can_status_irq: NOBJ must fit below the status identifier");
   end

   logic [7:0]       ctrl_q;
   stat_t            stat;
   logic             stat_pend;
   logic             obj_any;
   logic [IDX_W-1:0] obj_num;
   logic [15:0]      iid;
   logic             unused_wdata_hi;

   assign unused_wdata_hi = ^reg_wdata[15:8];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= '0;
      else if (reg_wr && reg_addr == ADR_CTRL)
         ctrl_q <= reg_wdata[7:0];
   end

   cstat_status u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .ev_lec_vld (pe_lec_vld),
      .ev_lec     (lec_e'(pe_lec)),
      .ev_tx_ok   (pe_tx_ok),
      .ev_rx_ok   (pe_rx_ok),
      .lv_warn    (pe_warn),
      .lv_pass    (pe_passive),
      .lv_boff    (pe_busoff),
      .sie        (ctrl_q[CB_SIE]),
      .eie        (ctrl_q[CB_EIE]),
      .cpu_wr     (reg_wr && reg_addr == ADR_STAT),
      .cpu_wdata  (reg_wdata[4:0]),
      .cpu_rd     (reg_rd && reg_addr == ADR_STAT),
      .stat       (stat),
      .stat_pend  (stat_pend)
   );

   cstat_lowest #(.N(NOBJ), .USE_ONEHOT(USE_ONEHOT)) u_low (
      .pend (obj_pend),
      .any  (obj_any),
      .num  (obj_num)
   );

   always_comb begin
      if (stat_pend)
         iid = IID_STATUS;
      else
         iid = 16'(obj_num);
   end

   always_comb begin
      unique case (reg_addr)
         ADR_CTRL: reg_rdata = {8'h00, ctrl_q};
         ADR_STAT: reg_rdata = {8'h00, stat};
         ADR_ERRC: reg_rdata = {pe_rec_passive, pe_rec, pe_tec};
         default:  reg_rdata = iid;
      endcase
   end

   assign irq = ctrl_q[CB_IE] & (iid != 16'h0000);

   a_r8_status_first: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(stat.txok) && $past(ctrl_q[CB_SIE])) |-> (iid == IID_STATUS));

   a_r9_lowest_is_set: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_pend && obj_any) |->
         (obj_pend[int'(obj_num) - 1] &&
          ((obj_pend & ((NOBJ'(1) << (obj_num - 1'b1)) - 1'b1)) == '0)));

   a_r9_none_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_pend && !obj_any) |-> (iid == 16'h0000));

   a_r10_irq_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ctrl_q[CB_IE]);

endmodule

// File: tb/can_status_irq_tb_top.sv
module can_status_irq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        pe_lec_vld = 1'b0;
   logic [2:0]  pe_lec = '0;
   logic        pe_tx_ok = 1'b0, pe_rx_ok = 1'b0;
   logic        pe_warn = 1'b0, pe_passive = 1'b0, pe_busoff = 1'b0;
   logic [7:0]  pe_tec = '0;
   logic [6:0]  pe_rec = '0;
   logic        pe_rec_passive = 1'b0;
   logic [31:0] obj_pend = '0;
   logic        irq;

   int nchk = 0;
   int nerr = 0;

   always #2 clk = ~clk;

   can_status_irq dut_i (.*);

   // {obj_pend, expected identifier}
   localparam logic [47:0] VEC [6] = '{
      {32'h0000_0000, 16'd0},
      {32'h0000_0001, 16'd1},
      {32'h8000_0000, 16'd32},
      {32'h8000_0010, 16'd5},
      {32'hFFFF_FFFF, 16'd1},
      {32'h0000_0300, 16'd9}
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic peek(input logic [1:0] a, output logic [15:0] v);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic rdclr(output logic [15:0] v);
      @(negedge clk);
      reg_addr = 2'd1; reg_rd = 1'b1;
      #1 v = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic lec_ev(input logic [2:0] c);
      @(negedge clk);
      pe_lec = c; pe_lec_vld = 1'b1;
      @(negedge clk);
      pe_lec_vld = 1'b0;
   endtask

   task automatic summary;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      logic [15:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      peek(2'd0, v); chk("R1 control", v, 16'h0000);
      peek(2'd1, v); chk("R1 status", v, 16'h0000);
      peek(2'd3, v); chk("R1 identifier", v, 16'h0000);
      chk("R1 irq", 16'(irq), 16'h0000);

      // R9 lowest pending object table
      for (int i = 0; i < 6; i++) begin
         obj_pend = VEC[i][47:16];
         peek(2'd3, v);
         chk($sformatf("R9 vector %0d", i), v, VEC[i][15:0]);
      end
      obj_pend = '0;

      // R11 error counter view
      pe_tec = 8'hA5; pe_rec = 7'h5A; pe_rec_passive = 1'b1;
      peek(2'd2, v); chk("R11 errcnt", v, 16'hDAA5);

      // R12 control store
      wr(2'd0, 16'hFFAE);
      peek(2'd0, v); chk("R12 control", v, 16'h00AE);

      // R5 / R4 / R8 with status-change enable only
      wr(2'd0, 16'h0004);
      @(negedge clk); pe_tx_ok = 1'b1; @(negedge clk); pe_tx_ok = 1'b0;
      peek(2'd1, v); chk("R4 txok set", v, 16'h0008);
      peek(2'd3, v); chk("R5 tx pends", v, 16'h8000);
      chk("R10 irq off without IE", 16'(irq), 16'h0000);
      obj_pend = 32'h0000_0004;
      peek(2'd3, v); chk("R8 overrides object", v, 16'h8000);

      // R7 read clears
      rdclr(v); chk("R7 read value", v, 16'h0008);
      peek(2'd3, v); chk("R7 cleared -> object 3", v, 16'd3);

      // R10 interrupt line
      wr(2'd0, 16'h0006);
      #1 chk("R10 irq with IE and object", 16'(irq), 16'h0001);
      obj_pend = '0;
      #1 chk("R10 irq low when idle", 16'(irq), 16'h0000);

      // R4 write-one no effect, write-zero clears
      wr(2'd1, 16'h0018);
      peek(2'd1, v); chk("R4 write ones", v, 16'h0008);
      wr(2'd1, 16'h0010);
      peek(2'd1, v); chk("R4 write zero clears", v, 16'h0000);

      // R3 last error code and sentinel
      lec_ev(3'd6);
      peek(2'd1, v); chk("R3 crc code", v, 16'h0006);
      rdclr(v);
      wr(2'd1, 16'h0007);
      repeat (3) @(negedge clk);
      peek(2'd1, v); chk("R3 sentinel holds", v, 16'h0007);
      peek(2'd3, v); chk("R5 write not an event", v, 16'h0000);
      @(negedge clk);
      reg_addr = 2'd1; reg_wdata = 16'h0007; reg_wr = 1'b1;
      pe_lec = 3'd2; pe_lec_vld = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; pe_lec_vld = 1'b0;
      peek(2'd1, v); chk("R3 event beats write", v, 16'h0002);
      rdclr(v);
      lec_ev(3'd0);
      peek(2'd1, v); chk("R3 none code", v, 16'h0000);
      rdclr(v);

      // R7 set wins over read
      @(negedge clk);
      reg_addr = 2'd1; reg_rd = 1'b1; pe_rx_ok = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0; pe_rx_ok = 1'b0;
      peek(2'd3, v); chk("R7 set wins", v, 16'h8000);
      rdclr(v); chk("R4 rxok set", v, 16'h0010);

      // R6 level changes with error enable only
      wr(2'd0, 16'h0008);
      @(negedge clk); pe_warn = 1'b1; @(negedge clk);
      peek(2'd3, v); chk("R6 warn rise", v, 16'h8000);
      rdclr(v);
      @(negedge clk); pe_passive = 1'b1; @(negedge clk);
      peek(2'd3, v); chk("R6 passive ignored", v, 16'h0000);
      @(negedge clk); pe_busoff = 1'b1; pe_warn = 1'b0; @(negedge clk);
      peek(2'd3, v); chk("R6 busoff rise", v, 16'h8000);
      peek(2'd1, v); chk("R2 level bits", v & 16'h00E0, 16'h00A0);
      rdclr(v);
      @(negedge clk);
      peek(2'd3, v); chk("R7 cleared after read", v, 16'h0000);

      // R5 / R6 gating off
      wr(2'd0, 16'h0000);
      @(negedge clk); pe_busoff = 1'b0; @(negedge clk);
      peek(2'd3, v); chk("R6 disabled", v, 16'h0000);
      @(negedge clk); pe_tx_ok = 1'b1; @(negedge clk); pe_tx_ok = 1'b0;
      peek(2'd3, v); chk("R5 disabled", v, 16'h0000);
      peek(2'd1, v); chk("R2 passive only", v & 16'h00E0, 16'h0020);

      summary();
      $finish;
   end

endmodule